// File: doc/BRIEF.md
# Tau-Dither Code Selector and Dither Phase Detector

This block sits in the code-tracking loop of a direct-sequence receiver. It runs on the reference clock, and one reference-clock cycle is one sub-chip step. It takes the local spreading-code chip stream and builds a lagged copy of it in a shift line. It then sends out a dithered code. The dithered code follows the on-time chips while the dither reference is low and the lagged chips while the reference is high.

The block also closes the digital half of the loop. It compares the hard-limited recovered dither signal with the dither reference, one bit per cycle, using an exclusive-OR. Only the sign of the dither is used. Over a fixed window of cycles it sums matches (+1) and mismatches (−1). At the end of each window it gives a one-cycle valid strobe together with an advance/retard direction for the code-clock divider. When the sum is exactly zero, the previous direction is kept.

Top module: `tau_dither_pd`

## Requirements
- R1: The lagged chip stream equals `chip_i` delayed by exactly `DELAY_STEPS` clock cycles. It reads 0 during the first `DELAY_STEPS` cycles after reset.
- R2: `dith_code_o` equals the on-time `chip_i` while `dith_ref_i` is 0 and the lagged chip while `dith_ref_i` is 1. It is a combinational selection in the same cycle.
- R3: Every clock cycle after reset, the block scores `dith_rx_i` XOR `dith_ref_i`. A result of 0 (match) adds +1 and a result of 1 (mismatch) adds −1 to the running window sum.
- R4: Windows are back to back and `WIN_LEN` cycles long. The first window starts with the first clock edge after reset is released. `dec_valid_o` is high for exactly the one cycle that follows the last cycle of each window, and never at any other time.
- R5: When the window sum is positive, `adv_o` becomes 1 (advance). When it is negative, `adv_o` becomes 0 (retard). The new value appears in the same cycle as `dec_valid_o`.
- R6: When the window sum is exactly zero, `adv_o` keeps its previous value. Outside a valid cycle, `adv_o` never changes.
- R7: While `rst_ni` is low, `dec_valid_o` and `adv_o` are 0. With `chip_i` at 0, `dith_code_o` is also 0.
- R8: The sum is cleared at every window boundary, so each decision depends only on the cycles of its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one cycle is one sub-chip step |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_i | input | 1 | On-time local spreading-code chip |
| dith_ref_i | input | 1 | Dither reference; also selects the lagged path |
| dith_rx_i | input | 1 | Hard-limited recovered dither signal |
| dith_code_o | output | 1 | Dithered code (on-time or lagged chip) |
| adv_o | output | 1 | Direction: 1 advance, 0 retard |
| dec_valid_o | output | 1 | One-cycle strobe when a window decision is issued |

## Verification
The chip stream is a pseudo-random sequence, and the dither reference toggles every two cycles. Checking `dith_code_o` on every cycle therefore separates the on-time path from the lagged path, and it also exposes an off-by-one in the lag length. This includes the zero-filled cycles just after reset. The phase comparator is driven with windows that fully match, fully mismatch, are exactly balanced, or are narrowly one-sided. These patterns separate the sign decision from the hold-on-tie rule. A balanced window that directly follows a strongly one-sided window shows whether the sum is truly cleared at each boundary.

// File: rtl/tdpd_pkg.sv
package tdpd_pkg;
  typedef enum logic {
    DIR_RETARD  = 1'b0,
    DIR_ADVANCE = 1'b1
  } dir_e;
endpackage

// File: rtl/tdpd_delay_line.sv
module tdpd_delay_line #(
  parameter int unsigned DELAY_STEPS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_i,
  output logic late_o
);
  logic [DELAY_STEPS-1:0] sr_q;

  generate
    if (DELAY_STEPS == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= chip_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DELAY_STEPS-2:0], chip_i};
      end
    end
  endgenerate

  assign late_o = sr_q[DELAY_STEPS-1];
endmodule

// File: rtl/tdpd_code_mux.sv
module tdpd_code_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_i,
  input  logic late_i,
  input  logic sel_late_i,
  output logic code_o
);
  assign code_o = sel_late_i ? late_i : chip_i;

  // both paths agree -> output cannot depend on select (R2)
  p_paths_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_i == late_i) |-> (code_o == chip_i));
endmodule

// File: rtl/tdpd_phase_acc.sv
module tdpd_phase_acc
  import tdpd_pkg::*;
#(
  parameter int unsigned WIN_LEN = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic rx_i,
  output logic adv_o,
  output logic valid_o
);
  localparam int unsigned CW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned AW = $clog2(WIN_LEN + 1) + 2;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0]        cnt_q;
  logic signed [AW-1:0] acc_q, sum;
  logic                 win_end;
  dir_e                 dir_q;
  logic                 valid_q;

  assign sum     = acc_q + ((rx_i ^ ref_i) ? AW'(-1) : AW'(1));
  assign win_end = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      dir_q   <= DIR_RETARD;
      valid_q <= 1'b0;
    end else begin
      valid_q <= win_end;
      if (win_end) begin
        cnt_q <= '0;
        acc_q <= '0;
        if (sum > 0)      dir_q <= DIR_ADVANCE;
        else if (sum < 0) dir_q <= DIR_RETARD;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= sum;
      end
    end
  end

  assign adv_o   = dir_q;
  assign valid_o = valid_q;

  p_valid_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_dir_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(adv_o));
  p_tie_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && sum == 0) |=> $stable(adv_o));
  p_acc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q <= $signed({2'b00, cnt_q})) && (acc_q >= -$signed({2'b00, cnt_q})));
endmodule

// File: rtl/tau_dither_pd.sv
module tau_dither_pd #(
  parameter int unsigned DELAY_STEPS = 5,
  parameter int unsigned WIN_LEN     = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_i,
  input  logic dith_ref_i,
  input  logic dith_rx_i,
  output logic dith_code_o,
  output logic adv_o,
  output logic dec_valid_o
);
  logic late;

  tdpd_delay_line #(.DELAY_STEPS(DELAY_STEPS)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .chip_i(chip_i),
    .late_o(late)
  );

  tdpd_code_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_i    (chip_i),
    .late_i    (late),
    .sel_late_i(dith_ref_i),
    .code_o    (dith_code_o)
  );

  tdpd_phase_acc #(.WIN_LEN(WIN_LEN)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (dith_ref_i),
    .rx_i   (dith_rx_i),
    .adv_o  (adv_o),
    .valid_o(dec_valid_o)
  );

  // R7: reset state of the decision path
  always_comb begin
    if (!rst_ni) begin
      a_reset_out_r7: assert (!dec_valid_o && !adv_o);
    end
  end
endmodule

// File: tb/sim_tau_dither_pd.sv
module sim_tau_dither_pd;
  localparam int D = 3;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic chip = 1'b0, dref = 1'b0, drx = 1'b0;
  logic code, adv, valid;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic hist[$];
  logic exp_q[$];
  logic model_adv = 1'b0;
  logic [6:0] lfsr = 7'h5a;
  bit done = 0;

  always #5 clk = ~clk;

  tau_dither_pd #(.DELAY_STEPS(D), .WIN_LEN(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .chip_i(chip), .dith_ref_i(dref),
    .dith_rx_i(drx), .dith_code_o(code), .adv_o(adv), .dec_valid_o(valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // one window: first n_match cycles agree, rest disagree
  task automatic run_window(input int n_match);
    int sum = 0;
    for (int i = 0; i < W; i++) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      chip = lfsr[0];
      dref = cyc[1];
      drx  = (i < n_match) ? dref : ~dref;
      sum += (i < n_match) ? 1 : -1;
      hist.push_back(chip);
      #1;
      chk(dref ? "R2/R1 late path" : "R2 on-time path", code,
          dref ? ((cyc >= D) ? hist[cyc - D] : 1'b0) : chip);
      @(negedge clk);
      cyc++;
    end
    if (sum > 0) model_adv = 1'b1;       // R5
    else if (sum < 0) model_adv = 1'b0;  // R5
    exp_q.push_back(model_adv);          // R6 keeps on zero
  endtask

  // monitor: scoreboard pop on each strobe
  int n_valid = 0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni && valid) begin
        n_valid++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected strobe act=1 exp=0");
        end else begin
          chk("R5/R6/R8 decision", adv, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R7 valid in reset", valid, 1'b0);
    chk("R7 adv in reset", adv, 1'b0);
    chk("R7 code in reset", code, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    run_window(8);  // all match -> advance
    run_window(0);  // all mismatch -> retard
    run_window(8);  // advance
    run_window(4);  // tie after advance -> keep 1 (R6, R8)
    run_window(3);  // -2 -> retard
    run_window(4);  // tie -> keep 0
    run_window(5);  // +2 -> advance
    run_window(0);  // strong retard
    run_window(4);  // tie after strong window -> keep 0 (R8)
    run_window(7);  // advance
    dref = 1'b0; drx = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk("R4 strobe count", n_valid == 10, 1'b1);
    chk("R4 queue drained", exp_q.size() == 0, 1'b1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule